// File: doc/BRIEF.md
# Stopwatch and Periodic Tick Timer

This block holds two independent counters that share one 16-bit status word. The first is a stopwatch. It advances one hundredth of a second on each 100 Hz enable strobe and keeps its count as packed hours, minutes, seconds and hundredths. Two match alarms watch it. The second is a millisecond counter. It advances on each 1 kHz enable strobe. When it reaches a programmed 16-bit value it raises a flag and starts again from zero.

Software reaches the block through a write-only register port. The status word, both counters and the interrupt are brought out as plain outputs, so a surrounding bus wrapper can read them. Logic outside the block produces the strobes from the oscillator.

Top module: `swpi_timer`

## Requirements
- R1: While rst_ni is low, status_o, sw_count_o and pi_count_o are all zero and irq_o is low.
- R2: When status bit 12 (stopwatch run) is set, each cycle with tick_100hz_i high advances the stopwatch by one hundredth. When bit 12 is clear, the stopwatch holds its value.
- R3: The stopwatch word holds hundredths in bits 6:0, seconds in bits 12:7, minutes in bits 18:13 and hours in bits 31:19. Hundredths roll from 99 to 0 and carry into seconds. Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours.
- R4: A write to address 2 (stopwatch alarm 1) sets the stopwatch count to zero in the same cycle. A write to address 3 (alarm 2) leaves the count unchanged.
- R5: Alarm 1 sets flag bit 8, and alarm 2 sets flag bit 10. Each flag is set when a stopwatch advance produces a value equal to that alarm, and only if three conditions hold: the alarm's enable is set (bit 9 for alarm 1, bit 11 for alarm 2), bit 12 is set, and the alarm's flag is clear.
- R6: When status bit 15 is set, each cycle with tick_1khz_i high advances the periodic counter by one. If the advanced value equals the low 16 bits of the match register (address 5), and bit 14 is set, and flag bit 13 is clear, then flag 13 is set and the counter goes to 0 instead. In every other case the counter keeps counting.
- R7: A write to address 0 (status) loads bits 9, 11, 12, 14 and 15 from the data. Flag bits 8, 10 and 13 are cleared where the data bit is 1 and kept where it is 0. If an alarm or match sets a flag in the same cycle, the set wins.
- R8: A write to address 1 loads the stopwatch count. A write to address 4 loads the periodic counter with the low 16 bits of the data. A count write in the same cycle as a strobe for that counter takes precedence, and that strobe is lost.
- R9: irq_o is high when any of these pairs is set: bits 8 and 9, bits 10 and 11, or bits 13 and 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_100hz_i | input | 1 | One-cycle stopwatch strobe |
| tick_1khz_i | input | 1 | One-cycle periodic counter strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register address: 0 status, 1 stopwatch count, 2 alarm 1, 3 alarm 2, 4 periodic count, 5 periodic match |
| wr_data_i | input | 32 | Write data |
| status_o | output | 16 | Status word |
| sw_count_o | output | 32 | Packed stopwatch count |
| pi_count_o | output | 16 | Periodic counter |
| irq_o | output | 1 | Interrupt |

## Verification
Two pairs of events can land in the same cycle.

- **Count write and strobe.** The bench writes the stopwatch count, and separately the periodic counter, in the same cycle as a strobe. It expects the written value to appear unchanged, not the value plus one.
- **Status write and flag set.** The bench writes the status word in the same cycle as the strobe that completes an alarm match. It expects the flag to come out set, and it expects the run and enable bits carried by that write to take effect.

// File: rtl/swpi_pkg.sv
package swpi_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned ST_W   = 16;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS   = 3'd0,
    REG_SW_COUNT = 3'd1,
    REG_SW_ALM1  = 3'd2,
    REG_SW_ALM2  = 3'd3,
    REG_PI_COUNT = 3'd4,
    REG_PI_MATCH = 3'd5
  } reg_addr_e;

  localparam int unsigned ST_SW1_FLAG = 8;
  localparam int unsigned ST_SW1_EN   = 9;
  localparam int unsigned ST_SW2_FLAG = 10;
  localparam int unsigned ST_SW2_EN   = 11;
  localparam int unsigned ST_SW_RUN   = 12;
  localparam int unsigned ST_PI_FLAG  = 13;
  localparam int unsigned ST_PI_EN    = 14;
  localparam int unsigned ST_PI_RUN   = 15;

  localparam logic [ST_W-1:0] ST_CTRL_MASK = 16'hDA00;
  localparam logic [ST_W-1:0] ST_FLAG_MASK = 16'h2500;
endpackage

// File: rtl/swpi_stopwatch.sv
module swpi_stopwatch #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned HUND_W   = 7,
  parameter int unsigned SEC_W    = 6,
  parameter int unsigned MIN_W    = 6,
  parameter int unsigned HOUR_W   = 13,
  parameter int unsigned HUND_MAX = 99,
  parameter int unsigned SEC_MAX  = 59,
  parameter int unsigned MIN_MAX  = 59,
  parameter int unsigned N_ALM    = 2,
  localparam int unsigned CNT_W   = HUND_W + SEC_W + MIN_W + HOUR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [N_ALM-1:0]  alm_en_i,
  input  logic [N_ALM-1:0]  alm_flag_i,
  input  logic              cnt_wr_i,
  input  logic [N_ALM-1:0]  alm_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [N_ALM-1:0]  hit_o
);
  localparam int unsigned SEC_LSB  = HUND_W;
  localparam int unsigned MIN_LSB  = SEC_LSB + SEC_W;
  localparam int unsigned HOUR_LSB = MIN_LSB + MIN_W;
  localparam logic [HUND_W-1:0] HUND_TOP = HUND_W'(HUND_MAX);
  localparam logic [SEC_W-1:0]  SEC_TOP  = SEC_W'(SEC_MAX);
  localparam logic [MIN_W-1:0]  MIN_TOP  = MIN_W'(MIN_MAX);

  logic [CNT_W-1:0]  count_q, count_nxt;
  logic [HUND_W-1:0] hund, hund_n;
  logic [SEC_W-1:0]  sec, sec_n;
  logic [MIN_W-1:0]  mins, mins_n;
  logic [HOUR_W-1:0] hour, hour_n;
  logic              c_hund, c_sec, c_min;
  logic              clr, adv;

  assign hund = count_q[SEC_LSB-1:0];
  assign sec  = count_q[MIN_LSB-1:SEC_LSB];
  assign mins = count_q[HOUR_LSB-1:MIN_LSB];
  assign hour = count_q[CNT_W-1:HOUR_LSB];

  // cascaded carries through the packed fields
  always_comb begin
    c_hund = (hund == HUND_TOP);
    c_sec  = c_hund && (sec == SEC_TOP);
    c_min  = c_sec && (mins == MIN_TOP);
    hund_n = c_hund ? '0 : hund + 1'b1;
    sec_n  = c_hund ? (c_sec ? '0 : sec + 1'b1) : sec;
    mins_n = c_sec ? (c_min ? '0 : mins + 1'b1) : mins;
    hour_n = c_min ? hour + 1'b1 : hour;
    count_nxt = {hour_n, mins_n, sec_n, hund_n};
  end

  assign clr = alm_wr_i[0];
  assign adv = tick_i && run_i && !cnt_wr_i && !clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (cnt_wr_i) count_q <= wr_data_i[CNT_W-1:0];
    else if (clr)      count_q <= '0;
    else if (adv)      count_q <= count_nxt;
  end

  for (genvar g = 0; g < N_ALM; g++) begin : g_alm
    logic [CNT_W-1:0] alarm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          alarm_q <= '0;
      else if (alm_wr_i[g]) alarm_q <= wr_data_i[CNT_W-1:0];
    end
    assign hit_o[g] = adv && alm_en_i[g] && !alm_flag_i[g] && (count_nxt == alarm_q);
  end

  assign count_o = count_q;
endmodule

// File: rtl/swpi_periodic.sv
module swpi_periodic #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PI_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              en_i,
  input  logic              flag_i,
  input  logic              cnt_wr_i,
  input  logic              match_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [PI_W-1:0]   count_o,
  output logic              hit_o
);
  logic [PI_W-1:0] count_q, match_q, count_nxt;
  logic            adv;

  assign count_nxt = count_q + 1'b1;
  assign adv       = tick_i && run_i && !cnt_wr_i;
  assign hit_o     = adv && en_i && !flag_i && (count_nxt == match_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (cnt_wr_i) count_q <= wr_data_i[PI_W-1:0];
    else if (hit_o)    count_q <= '0;
    else if (adv)      count_q <= count_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         match_q <= '0;
    else if (match_wr_i) match_q <= wr_data_i[PI_W-1:0];
  end

  assign count_o = count_q;
endmodule

// File: rtl/swpi_status.sv
module swpi_status
  import swpi_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        sw_hit_i,
  input  logic              pi_hit_i,
  output logic [ST_W-1:0]   status_o,
  output logic              irq_o
);
  logic [ST_W-1:0] st_q, st_d, set_v, wdat;

  assign wdat = wr_data_i[ST_W-1:0];

  always_comb begin
    set_v = '0;
    set_v[ST_SW1_FLAG] = sw_hit_i[0];
    set_v[ST_SW2_FLAG] = sw_hit_i[1];
    set_v[ST_PI_FLAG]  = pi_hit_i;
    st_d = st_q;
    if (st_wr_i) st_d = (wdat & ST_CTRL_MASK) | (st_q & ST_FLAG_MASK & ~wdat);
    st_d = st_d | set_v;  // new event beats write-one-to-clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign irq_o = (st_q[ST_SW1_FLAG] && st_q[ST_SW1_EN]) ||
                 (st_q[ST_SW2_FLAG] && st_q[ST_SW2_EN]) ||
                 (st_q[ST_PI_FLAG]  && st_q[ST_PI_EN]);
  assign status_o = st_q;
endmodule

// File: rtl/swpi_timer.sv
module swpi_timer
  import swpi_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PI_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_100hz_i,
  input  logic              tick_1khz_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [ST_W-1:0]   status_o,
  output logic [DATA_W-1:0] sw_count_o,
  output logic [PI_W-1:0]   pi_count_o,
  output logic              irq_o
);
  localparam int unsigned N_ALM = 2;
  localparam int unsigned SW_W  = 32;

  logic [ST_W-1:0]  st;
  logic [SW_W-1:0]  sw_cnt;
  logic [N_ALM-1:0] sw_hit, alm_wr;
  logic             pi_hit;
  logic             wr_st, wr_swc, wr_pic, wr_pim;

  assign wr_st     = wr_en_i && (wr_addr_i == REG_STATUS);
  assign wr_swc    = wr_en_i && (wr_addr_i == REG_SW_COUNT);
  assign alm_wr[0] = wr_en_i && (wr_addr_i == REG_SW_ALM1);
  assign alm_wr[1] = wr_en_i && (wr_addr_i == REG_SW_ALM2);
  assign wr_pic    = wr_en_i && (wr_addr_i == REG_PI_COUNT);
  assign wr_pim    = wr_en_i && (wr_addr_i == REG_PI_MATCH);

  swpi_status #(.DATA_W(DATA_W)) i_status (
    .clk_i, .rst_ni,
    .st_wr_i  (wr_st),
    .wr_data_i,
    .sw_hit_i (sw_hit),
    .pi_hit_i (pi_hit),
    .status_o (st),
    .irq_o
  );

  swpi_stopwatch #(.DATA_W(DATA_W), .N_ALM(N_ALM)) i_sw (
    .clk_i, .rst_ni,
    .tick_i     (tick_100hz_i),
    .run_i      (st[ST_SW_RUN]),
    .alm_en_i   ({st[ST_SW2_EN], st[ST_SW1_EN]}),
    .alm_flag_i ({st[ST_SW2_FLAG], st[ST_SW1_FLAG]}),
    .cnt_wr_i   (wr_swc),
    .alm_wr_i   (alm_wr),
    .wr_data_i,
    .count_o    (sw_cnt),
    .hit_o      (sw_hit)
  );

  swpi_periodic #(.DATA_W(DATA_W), .PI_W(PI_W)) i_pi (
    .clk_i, .rst_ni,
    .tick_i     (tick_1khz_i),
    .run_i      (st[ST_PI_RUN]),
    .en_i       (st[ST_PI_EN]),
    .flag_i     (st[ST_PI_FLAG]),
    .cnt_wr_i   (wr_pic),
    .match_wr_i (wr_pim),
    .wr_data_i,
    .count_o    (pi_count_o),
    .hit_o      (pi_hit)
  );

  assign status_o   = st;
  assign sw_count_o = DATA_W'(sw_cnt);
endmodule

// File: rtl/swpi_timer_chk.sv
module swpi_timer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PI_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_100hz_i,
  input logic              tick_1khz_i,
  input logic              wr_en_i,
  input logic [2:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [15:0]       status_o,
  input logic [DATA_W-1:0] sw_count_o,
  input logic [PI_W-1:0]   pi_count_o,
  input logic              irq_o
);
  logic sw_touch, pi_touch, st_touch;
  assign sw_touch = wr_en_i && (wr_addr_i == 3'd1 || wr_addr_i == 3'd2);
  assign pi_touch = wr_en_i && (wr_addr_i == 3'd4);
  assign st_touch = wr_en_i && (wr_addr_i == 3'd0);

  a_r2_sw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[12] && !sw_touch) |=> $stable(sw_count_o));
  a_r4_alarm1_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd2) |=> (sw_count_o == '0));
  a_r6_pi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[15] && !pi_touch) |=> $stable(pi_count_o));
  a_r6_restart_on_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[13]) |-> (pi_count_o == '0));
  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[8] && !st_touch) |=> status_o[8]);
  a_r8_pi_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pi_touch |=> (pi_count_o == $past(wr_data_i[PI_W-1:0])));
  a_r9_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o[8] || status_o[10] || status_o[13]));
endmodule

bind swpi_timer swpi_timer_chk #(.DATA_W(DATA_W), .PI_W(PI_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_100hz_i(tick_100hz_i),
  .tick_1khz_i(tick_1khz_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .status_o(status_o), .sw_count_o(sw_count_o),
  .pi_count_o(pi_count_o), .irq_o(irq_o)
);

// File: tb/test_swpi_timer.sv
module test_swpi_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        t100 = 1'b0, t1k = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] status;
  logic [31:0] sw_cnt;
  logic [15:0] pi_cnt;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swpi_timer i_swpi_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_100hz_i(t100), .tick_1khz_i(t1k),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .status_o(status), .sw_count_o(sw_cnt), .pi_count_o(pi_cnt), .irq_o(irq)
  );

  function automatic logic [31:0] pk(int h, int m, int s, int c);
    return (32'(h) << 19) | (32'(m) << 13) | (32'(s) << 7) | 32'(c);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, result visible at next negedge
  task automatic cyc(bit we, logic [2:0] a, logic [31:0] d, bit s100, bit s1k);
    wr_en = we; wr_addr = a; wr_data = d; t100 = s100; t1k = s1k;
    @(negedge clk);
    wr_en = 1'b0; t100 = 1'b0; t1k = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d); cyc(1'b1, a, d, 1'b0, 1'b0); endtask
  task automatic sw_tick(); cyc(1'b0, 3'd0, 32'd0, 1'b1, 1'b0); endtask
  task automatic pi_tick(); cyc(1'b0, 3'd0, 32'd0, 1'b0, 1'b1); endtask

  task automatic t_reset();
    chk("R1 status", 32'(status), 0);
    chk("R1 sw count", sw_cnt, 0);
    chk("R1 pi count", 32'(pi_cnt), 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_sw_run();
    sw_tick();
    chk("R2 stopped hold", sw_cnt, 0);
    wr(3'd0, 32'h1000);
    for (int i = 0; i < 3; i++) sw_tick();
    chk("R2 three ticks", sw_cnt, 3);
    wr(3'd0, 32'h0000);
    sw_tick();
    chk("R2 hold after stop", sw_cnt, 3);
  endtask

  task automatic t_sw_carry();
    wr(3'd0, 32'h1000);
    wr(3'd1, pk(0, 0, 5, 99));
    sw_tick();
    chk("R3 hundredths carry", sw_cnt, pk(0, 0, 6, 0));
    wr(3'd1, pk(1, 59, 59, 99));
    sw_tick();
    chk("R3 full carry to hours", sw_cnt, pk(2, 0, 0, 0));
  endtask

  task automatic t_alarm_write();
    wr(3'd1, pk(0, 3, 4, 5));
    wr(3'd3, pk(0, 3, 4, 7));
    chk("R4 alarm2 write keeps count", sw_cnt, pk(0, 3, 4, 5));
    wr(3'd2, 32'd3);
    chk("R4 alarm1 write clears", sw_cnt, 0);
  endtask

  task automatic t_alarms();
    wr(3'd0, 32'h0200);  // enable, no run
    sw_tick(); sw_tick(); sw_tick();
    chk("R5 no fire while stopped", 32'(status), 32'h0200);
    wr(3'd0, 32'h1200);
    sw_tick(); sw_tick();
    chk("R5 before match", 32'(status), 32'h1200);
    // status write rewriting controls coincides with the matching tick
    cyc(1'b1, 3'd0, 32'h1A00, 1'b1, 1'b0);
    chk("R7 set wins over status write", 32'(status), 32'h1B00);
    chk("R9 irq alarm1", 32'(irq), 1);
    wr(3'd0, 32'h1A00);
    chk("R7 zero keeps flag", 32'(status), 32'h1B00);
    wr(3'd0, 32'h1900);
    chk("R7 w1c flag8", 32'(status), 32'h1800);
    chk("R9 irq cleared", 32'(irq), 0);
    wr(3'd3, 32'd5);
    sw_tick(); sw_tick();
    chk("R5 alarm2 flag", 32'(status), 32'h1C00);
    chk("R9 irq alarm2", 32'(irq), 1);
    wr(3'd0, 32'h1000);
    chk("R9 masked by enable", 32'(irq), 0);
    chk("R7 flag10 kept", 32'(status), 32'h1400);
    wr(3'd0, 32'h0400);
  endtask

  task automatic t_alarm_disabled();
    wr(3'd0, 32'h1000);
    wr(3'd2, 32'd2);
    sw_tick(); sw_tick();
    chk("R5 disabled alarm silent", 32'(status), 32'h1000);
    wr(3'd0, 32'h0000);
  endtask

  task automatic t_periodic();
    wr(3'd5, 32'h0001_0005);
    pi_tick();
    chk("R6 stopped hold", 32'(pi_cnt), 0);
    wr(3'd0, 32'hC000);
    for (int i = 0; i < 4; i++) pi_tick();
    chk("R6 count before match", 32'(pi_cnt), 4);
    chk("R6 no flag yet", 32'(status), 32'hC000);
    pi_tick();
    chk("R6 restart at match", 32'(pi_cnt), 0);
    chk("R6 flag13", 32'(status), 32'hE000);
    chk("R9 irq pi", 32'(irq), 1);
    for (int i = 0; i < 6; i++) pi_tick();
    chk("R6 no restart with flag set", 32'(pi_cnt), 6);
    wr(3'd0, 32'hE000);
    chk("R7 w1c flag13", 32'(status), 32'hC000);
    wr(3'd4, 32'h0001_2345);
    chk("R8 pi low 16 bits", 32'(pi_cnt), 32'h2345);
  endtask

  task automatic t_collide();
    wr(3'd0, 32'h9000);
    cyc(1'b1, 3'd1, 32'h42, 1'b1, 1'b0);
    chk("R8 sw write beats tick", sw_cnt, 32'h42);
    cyc(1'b1, 3'd4, 32'h3, 1'b0, 1'b1);
    chk("R8 pi write beats tick", 32'(pi_cnt), 3);
    cyc(1'b1, 3'd2, 32'h9, 1'b1, 1'b0);
    chk("R4 alarm1 write beats tick", sw_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sw_run();
    t_sw_carry();
    t_alarm_write();
    t_alarms();
    t_alarm_disabled();
    t_periodic();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule